// File: doc/BRIEF.md
# Cascaded Wide Programmable Divider

This block builds a wide synchronous counter from a row of narrow presettable counter slices that share one clock. Each slice flags an active-low terminal count when all of its bits are ones. A slice steps only when the global enable is high and every slice below it is at all ones. This works as a carry look-ahead: the OR of the lower active-low terminal counts is the slice's own active-low step enable. On the edge where an upper slice steps, the lower slices wrap to zero at the same time. Their terminal counts then go high again, and the upper slice falls back to hold.

In counting mode the word runs freely and wraps from all ones to zero. In divider mode every slice takes its load enable from the OR of all slices' terminal counts. The whole word reloads the preset only on the cycle after it reaches all ones. With a preset of 2^W − N the chain divides by N, for any N from 2 to 2^W, where W is the word width. The active-low wide terminal count is the divided pulse. A toggle stage flips once per terminal-count pulse, which gives a 50% duty-cycle output with twice the chain's period. An external active-low load forces the preset into the word in either mode.

Top module: `divChainTop`

## Requirements
- R1: An active-low `rstN` clears `count` to zero and `sqOut` to 0 asynchronously, without waiting for a clock edge.
- R2: In counting mode (`divMode`=0), with `loadN` high and `countEn` high, `count` increases by one at each rising edge and wraps from all ones to zero.
- R3: With `loadN` high and `countEn` low, `count` holds its value. The one exception is the divider reload of R5.
- R4: `loadN` low at a rising edge loads `preset` into `count` in either mode, whatever `countEn` is. It takes priority over counting.
- R5: In divider mode (`divMode`=1), the edge after `count` is all ones loads `preset`, whatever `countEn` is. No other word value causes a reload.
- R6: `tcN` is 0 exactly when every bit of `count` is 1, and 1 otherwise.
- R7: `sqOut` inverts at a rising edge when `tcN` is 0 and either `countEn` or `divMode` is 1. Otherwise it holds.
- R8: In divider mode with `countEn` high and `preset` = 2^W − N, where 2 ≤ N ≤ 2^W, `tcN` pulses low once every N cycles.
- R9: A slice steps only when all lower slices are at all ones, and at that edge the lower slices wrap to zero. A word whose lower slices are all ones carries into every upper slice in a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all slices |
| rstN | input | 1 | Asynchronous reset, active low |
| loadN | input | 1 | External preset load, active low |
| countEn | input | 1 | Global count enable, active high |
| divMode | input | 1 | 1 = reload on wide terminal count, 0 = free-running count |
| preset | input | SLICE_W*NUM_SLICES | Value loaded by an external load or a divider reload |
| count | output | SLICE_W*NUM_SLICES | Current wide count |
| tcN | output | 1 | Wide terminal count, active low (the divided pulse) |
| sqOut | output | 1 | Toggle-stage output, inverts on each terminal-count pulse |

## Verification
Each change to `count` and `sqOut` is due one rising edge after the inputs that cause it. `tcN` follows `count` combinationally in the same cycle. The bench applies inputs at a falling edge and advances its reference model across the next rising edge. It then compares `count`, `tcN` and `sqOut` at the following falling edge, so every comparison lands one full edge after its stimulus. The divide-ratio checks count the cycles between two successive low samples of `tcN`, which measures the reload period directly in clock cycles.

// File: rtl/divChainPkg.sv
package divChainPkg;
  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic loadN;   // active-low load applied to every slice
    logic toggle;  // invert the toggle stage at this edge
  } chainStrobe_t;
endpackage

// File: rtl/divChainSlice.sv
module divChainSlice #(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               peN,
  input  logic               ceN,
  input  logic [SLICE_W-1:0] pData,
  output logic [SLICE_W-1:0] q,
  output logic               tcN
);
  localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

  // Load outranks counting; counting outranks hold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= '0;
    else if (!peN)  q <= pData;
    else if (!ceN)  q <= q + ONE;
  end

  assign tcN = ~(&q);
endmodule

// File: rtl/divChainCtrl.sv
module divChainCtrl
  import divChainPkg::*;
#(
  parameter int NUM_SLICES = 4
) (
  input  logic                  countEn,
  input  logic                  loadN,
  input  logic                  divMode,
  input  logic [NUM_SLICES-1:0] sliceTcN,
  output logic [NUM_SLICES-1:0] ceN,
  output logic                  wideTcN,
  output chainStrobe_t          strobe
);
  // Carry look-ahead: slice k's enable is the OR of the global enable
  // (inverted) and every lower active-low terminal count.
  assign ceN[0] = ~countEn;
  for (genvar k = 1; k < NUM_SLICES; k++) begin : g_carry
    assign ceN[k] = ceN[k-1] | sliceTcN[k-1];
  end

  // The word is all ones only when every slice is.
  assign wideTcN = |sliceTcN;

  always_comb begin
    strobe.loadN  = loadN & (~divMode | wideTcN);
    strobe.toggle = ~wideTcN & (countEn | divMode);
  end
endmodule

// File: rtl/divChainPath.sv
module divChainPath
  import divChainPkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 4,
  localparam int WORD_W    = SLICE_W * NUM_SLICES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chainStrobe_t          strobe,
  input  logic [NUM_SLICES-1:0] ceN,
  input  logic [WORD_W-1:0]     preset,
  output logic [WORD_W-1:0]     count,
  output logic [NUM_SLICES-1:0] sliceTcN,
  output logic                  sqOut
);
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    divChainSlice #(.SLICE_W(SLICE_W)) u_slice (
      .clk   (clk),
      .rstN  (rstN),
      .peN   (strobe.loadN),
      .ceN   (ceN[k]),
      .pData (preset[k*SLICE_W +: SLICE_W]),
      .q     (count[k*SLICE_W +: SLICE_W]),
      .tcN   (sliceTcN[k])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sqOut <= 1'b0;
    else if (strobe.toggle) sqOut <= ~sqOut;
  end
endmodule

// File: rtl/divChainTop.sv
module divChainTop
  import divChainPkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 4,
  localparam int WORD_W    = SLICE_W * NUM_SLICES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              countEn,
  input  logic              divMode,
  input  logic [WORD_W-1:0] preset,
  output logic [WORD_W-1:0] count,
  output logic              tcN,
  output logic              sqOut
);
  chainStrobe_t          strobe;
  logic [NUM_SLICES-1:0] ceN;
  logic [NUM_SLICES-1:0] sliceTcN;

  divChainCtrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .countEn  (countEn),
    .loadN    (loadN),
    .divMode  (divMode),
    .sliceTcN (sliceTcN),
    .ceN      (ceN),
    .wideTcN  (tcN),
    .strobe   (strobe)
  );

  divChainPath #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ceN      (ceN),
    .preset   (preset),
    .count    (count),
    .sliceTcN (sliceTcN),
    .sqOut    (sqOut)
  );
endmodule

// File: rtl/divChainChk.sv
module divChainChk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadN,
  input logic              countEn,
  input logic              divMode,
  input logic [WORD_W-1:0] preset,
  input logic [WORD_W-1:0] count,
  input logic              tcN,
  input logic              sqOut
);
  // R1: while reset is held, word and toggle are clear
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r1: assert (count == '0 && sqOut == 1'b0);
    end
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !divMode && countEn) |=> count == $past(count) + WORD_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !countEn && !(divMode && !tcN)) |=> $stable(count));

  p_ext_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> count == $past(preset));

  p_div_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (divMode && !tcN) |=> count == $past(preset));

  p_tc_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    tcN == !(&count));

  p_sq_flip_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!tcN && (countEn || divMode)) |=> sqOut != $past(sqOut));

  p_sq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(!tcN && (countEn || divMode)) |=> $stable(sqOut));
endmodule

bind divChainTop divChainChk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadN   (loadN),
  .countEn (countEn),
  .divMode (divMode),
  .preset  (preset),
  .count   (count),
  .tcN     (tcN),
  .sqOut   (sqOut)
);

// File: tb/divChainTop_tb.sv
`timescale 1ns/1ps
module divChainTop_tb;
  localparam int SW  = 4;
  localparam int NS  = 4;
  localparam int W   = SW * NS;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadN = 1'b1;
  logic countEn = 1'b0;
  logic divMode = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic tcN, sqOut;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  logic [W-1:0] refCnt = '0;
  logic refSq = 1'b0;

  always #4 clk = ~clk;

  divChainTop #(.SLICE_W(SW), .NUM_SLICES(NS)) u_dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .countEn(countEn),
    .divMode(divMode), .preset(preset), .count(count), .tcN(tcN), .sqOut(sqOut)
  );

  function automatic logic [W-1:0] nextCnt(logic [W-1:0] c, logic ld, logic ce,
                                           logic dm, logic [W-1:0] pr);
    if (!ld || (dm && c == ALL1)) return pr;
    if (ce) return c + W'(1);
    return c;
  endfunction

  function automatic logic nextSq(logic s, logic [W-1:0] c, logic ce, logic dm);
    return (c == ALL1 && (ce || dm)) ? ~s : s;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, compare.
  task automatic step(input logic ld, input logic ce, input logic dm, input logic [W-1:0] pr);
    string tag;
    if (!ld) tag = "R4";
    else if (dm && refCnt == ALL1) tag = "R5";
    else if (ce) tag = "R2";
    else tag = "R3";
    loadN = ld; countEn = ce; divMode = dm; preset = pr;
    refSq  = nextSq(refSq, refCnt, ce, dm);
    refCnt = nextCnt(refCnt, ld, ce, dm, pr);
    @(posedge clk);
    @(negedge clk);
    check({tag, " count"}, count, refCnt);
    check("R6 tcN", W'(tcN), W'(refCnt != ALL1));
    check("R7 sqOut", W'(sqOut), W'(refSq));
  endtask

  // R8: load 2^W - n, then measure cycles between two low tcN samples.
  task automatic measureRatio(input int n);
    logic [W-1:0] pr;
    int gap;
    pr = W'((1 << W) - n);
    step(1'b0, 1'b1, 1'b1, pr);
    while (tcN) step(1'b1, 1'b1, 1'b1, pr);
    gap = 0;
    do begin
      step(1'b1, 1'b1, 1'b1, pr);
      gap++;
    end while (tcN);
    check("R8 ratio", W'(gap), W'(n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset count", count, '0);
    check("R1 reset sq", W'(sqOut), '0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 free count and wrap; R9 carries into upper slices
    step(1'b0, 1'b0, 1'b0, 16'h00FF);
    step(1'b1, 1'b1, 1'b0, '0);
    check("R9 carry slice1", count, 16'h0100);
    step(1'b0, 1'b0, 1'b0, 16'h0FFF);
    step(1'b1, 1'b1, 1'b0, '0);
    check("R9 carry slice3", count, 16'h1000);
    step(1'b0, 1'b0, 1'b0, 16'hFFFE);
    step(1'b1, 1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 1'b0, '0);
    check("R2 wrap", count, 16'h0000);
    // R3 hold in counting mode at all ones
    step(1'b0, 1'b0, 1'b0, ALL1);
    repeat (3) step(1'b1, 1'b0, 1'b0, 16'h1234);
    check("R3 hold at all ones", count, ALL1);
    // R5 reload with countEn low; lower slices all ones only: no reload
    step(1'b1, 1'b0, 1'b1, 16'h4321);
    check("R5 reload no enable", count, 16'h4321);
    step(1'b0, 1'b0, 1'b1, 16'h0FFF);
    step(1'b1, 1'b1, 1'b1, 16'h5555);
    check("R5 partial ones no reload", count, 16'h1000);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic ld, ce, dm;
      logic [W-1:0] pr;
      ld = ($urandom % 20) != 0;
      ce = ($urandom % 4) != 0;
      dm = ((i / 250) % 2) == 1;
      case ($urandom % 3)
        0: pr = ALL1 - W'($urandom % 24);
        1: pr = W'($urandom);
        default: pr = W'({$urandom % 16, 4'hF, 4'hF, 4'h0 | 4'($urandom % 3 + 13)});
      endcase
      step(ld, ce, dm, pr);
    end

    // R1 asynchronous reset mid-run
    step(1'b0, 1'b0, 1'b0, 16'hABCD);
    #1 rstN = 1'b0;
    #1 check("R1 async count", count, '0);
    check("R1 async sq", W'(sqOut), '0);
    refCnt = '0; refSq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    measureRatio(2);
    measureRatio(3);
    measureRatio(113);
    measureRatio(1 << W);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule